// File: doc/BRIEF.md
# Pixel FIFO and Interrupt Front End for a Serial RGB LED Chain

This block sits between a simple register bus and the bit serializer of an addressable RGB LED chain. Software, or a DMA engine, writes 32-bit pixel words into a data register. Those words go into a 32-entry FIFO. The serializer drains the FIFO through a valid/ready pair. When the last pixel and the latch gap after it have gone out, the serializer pulses `frame_done` back.

A control register enables the frame and holds its length in pixels and a colour-order code. That code is only passed on to the serializer. A request generator compares the live FIFO fill with a programmable trigger level. It asks for more data while the frame still has words to fetch. That request appears as a sticky interrupt flag and, when DMA is enabled, as a level `dma_req` output. The fill count can be read in the status word, so an interrupt handler knows how many words it may push without overflow.

The bus is a single-cycle valid/write/address interface with word addresses. Reads are combinational on `bus_addr`.

Top module: `pixq_front`

## Requirements
- R1: After reset every register field, both flags and the FIFO fill are zero, and `px_valid`, `dma_req`, `irq` and `run_en` are low.
- R2: Word addresses on `bus_addr` are 0 control, 1 DMA control, 2 interrupt enable, 3 status and 4 pixel data. Control holds enable at bit 0, colour order at bits 8:6 and frame length at bits 28:16. DMA control holds DMA enable at bit 5 and trigger level at bits 4:0. Interrupt enable holds the global enable at bit 5, the request enable at bit 1 and the finish enable at bit 0. Each of these fields reads back as written. The data address and the unused addresses 5 to 7 read as zero.
- R3: A frame length above 1024 written to control is stored, and read back, as 1024.
- R4: A write to the data address pushes `bus_wdata` only when the block is enabled and the fill was below 32 before that edge. Any other data write is dropped and leaves the FIFO unchanged.
- R5: `px_valid` is high whenever the FIFO holds a word, and `px_data` is the oldest word. A cycle with `px_ready` high removes it, and words leave in the order they were accepted.
- R6: The request condition is: enabled, fill below the trigger level, and fewer words accepted in this frame than the frame length. `dma_req` equals this condition while DMA enable is 1 and is low otherwise.
- R7: A control write that clears the enable bit empties the FIFO on that edge and restarts the accepted-word count of the frame.
- R8: A `frame_done` pulse while enabled sets the finish flag, clears the enable bit and empties the FIFO. While disabled the pulse has no effect.
- R9: `irq` = global enable AND ((finish flag AND finish enable) OR (request flag AND request enable)).
- R10: Status shows the FIFO fill at bits 15:10, the request flag at bit 1 and the finish flag at bit 0. Writing 1 to a flag bit clears it, and a set event in the same cycle wins over the clear.
- R11: The request flag is set on every edge at which the request condition held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus cycle strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| px_data | output | 32 | Oldest FIFO word to serializer |
| px_valid | output | 1 | FIFO not empty |
| px_ready | input | 1 | Serializer takes the word this cycle |
| frame_done | input | 1 | Serializer pulse: frame and latch gap finished |
| run_en | output | 1 | Enable bit to serializer |
| frame_len | output | 13 | Frame length in pixels to serializer |
| color_order | output | 3 | Colour-order code to serializer |
| dma_req | output | 1 | Level DMA refill request |
| irq | output | 1 | Interrupt |

## Verification
The hardest state to reach from the ports is a full FIFO in the middle of a long frame. At that point the request must stop because of fill while words are still owed. It must then resume as the serializer drains, and stop for good once the accepted count reaches the frame length. The stimulus pushes 33 words with `px_ready` held low, so the last push is dropped and the FIFO is full. It then drains with `px_ready` while topping up, until a 40-pixel frame is exhausted. After that, a long random phase mixes enable toggles, `frame_done` pulses and W1C writes against a behavioural queue model that is checked every cycle.

// File: rtl/pixq_pkg.sv
package pixq_pkg;
   localparam int unsigned BUS_W = 32;
   localparam int unsigned ADDR_W = 3;

   localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
   localparam logic [ADDR_W-1:0] A_DMA  = 3'd1;
   localparam logic [ADDR_W-1:0] A_IEN  = 3'd2;
   localparam logic [ADDR_W-1:0] A_STAT = 3'd3;
   localparam logic [ADDR_W-1:0] A_DATA = 3'd4;

   localparam int unsigned CTRL_EN_BIT   = 0;
   localparam int unsigned CTRL_ORD_LSB  = 6;
   localparam int unsigned CTRL_LEN_LSB  = 16;
   localparam int unsigned DMA_EN_BIT    = 5;
   localparam int unsigned DMA_TRIG_LSB  = 0;
   localparam int unsigned IEN_GLB_BIT   = 5;
   localparam int unsigned IEN_REQ_BIT   = 1;
   localparam int unsigned IEN_FIN_BIT   = 0;
   localparam int unsigned STAT_FILL_LSB = 10;
   localparam int unsigned STAT_FILL_W   = 6;
   localparam int unsigned STAT_REQ_BIT  = 1;
   localparam int unsigned STAT_FIN_BIT  = 0;
   localparam int unsigned ORD_W         = 3;
endpackage

// File: rtl/pixq_fifo.sv
module pixq_fifo #(
   parameter int unsigned WIDTH = 32,
   parameter int unsigned DEPTH = 32,
   localparam int unsigned CNT_W = $clog2(DEPTH + 1),
   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push,
   input  logic [WIDTH-1:0] wdata,
   input  logic             pop,
   output logic [WIDTH-1:0] rdata,
   output logic [CNT_W-1:0] count,
   output logic             full,
   output logic             empty
);
   if (DEPTH < 2) $error("pixq_fifo: DEPTH must be at least 2");

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic push_ok, pop_ok;

   assign full    = (count == CNT_W'(DEPTH));
   assign empty   = (count == '0);
   assign push_ok = push & ~full;
   assign pop_ok  = pop & ~empty;
   assign rdata   = mem[rd_ptr];

   if ((1 << PTR_W) == DEPTH) begin : g_pow2
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
   end else begin : g_wrap
      assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_nxt;
         if (pop_ok)  rd_ptr <= rd_nxt;
         count <= count + CNT_W'(push_ok) - CNT_W'(pop_ok);
      end
   end

   a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));
   a_r4_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop && !flush) |=> (count == CNT_W'(DEPTH)));
   a_r7_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> empty);
endmodule

// File: rtl/pixq_reqgen.sv
module pixq_reqgen #(
   parameter int unsigned LEN_W  = 13,
   parameter int unsigned TRIG_W = 5,
   parameter int unsigned CNT_W  = 6,
   localparam int unsigned SENT_W = LEN_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              restart,
   input  logic              accepted,
   input  logic [LEN_W-1:0]  len,
   input  logic [CNT_W-1:0]  fill,
   input  logic [TRIG_W-1:0] trig,
   input  logic              dma_en,
   output logic              req_cond,
   output logic              dma_req
);
   logic [SENT_W-1:0] taken;
   logic              below_trig, owed;

   assign below_trig = 32'(fill) < 32'(trig);
   assign owed       = taken < {1'b0, len};
   assign req_cond   = en & below_trig & owed;
   assign dma_req    = req_cond & dma_en;

   always_ff @(posedge clk) begin
      if (!rst_n || restart) taken <= '0;
      else if (accepted && taken != '1) taken <= taken + 1'b1;
   end

   a_r7_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (taken == '0));
   a_r6_dma_only_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req |-> (en && fill < CNT_W'(trig)));
endmodule

// File: rtl/pixq_regs.sv
module pixq_regs
   import pixq_pkg::*;
#(
   parameter int unsigned LEN_W   = 13,
   parameter int unsigned MAX_PIX = 1024,
   parameter int unsigned TRIG_W  = 5,
   parameter int unsigned CNT_W   = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   input  logic              frame_done,
   input  logic              req_cond,
   input  logic [CNT_W-1:0]  fill,
   output logic              en,
   output logic [LEN_W-1:0]  len,
   output logic [ORD_W-1:0]  order,
   output logic              dma_en,
   output logic [TRIG_W-1:0] trig,
   output logic              flush,
   output logic              restart,
   output logic              data_wr,
   output logic [BUS_W-1:0]  rdata,
   output logic              irq
);
   if (CTRL_LEN_LSB + LEN_W > BUS_W) $error("pixq_regs: LEN_W too wide");
   if (MAX_PIX >= (1 << LEN_W)) $error("pixq_regs: MAX_PIX needs a wider LEN_W");
   if (CNT_W > STAT_FILL_W) $error("pixq_regs: fill does not fit status field");
   if (TRIG_W > DMA_EN_BIT) $error("pixq_regs: trigger overlaps DMA enable");

   logic wr, wr_ctrl, wr_dma, wr_ien, wr_stat;
   logic en_next, fin_evt;
   logic glb_ie, req_ie, fin_ie, req_flag, fin_flag;
   logic [LEN_W-1:0] wlen, wlen_clamped;

   assign wr      = bus_valid & bus_write;
   assign wr_ctrl = wr && bus_addr == A_CTRL;
   assign wr_dma  = wr && bus_addr == A_DMA;
   assign wr_ien  = wr && bus_addr == A_IEN;
   assign wr_stat = wr && bus_addr == A_STAT;
   assign data_wr = wr && bus_addr == A_DATA && en;

   assign wlen         = bus_wdata[CTRL_LEN_LSB +: LEN_W];
   assign wlen_clamped = (32'(wlen) > MAX_PIX) ? LEN_W'(MAX_PIX) : wlen;

   assign fin_evt = frame_done & en;
   assign en_next = fin_evt ? 1'b0 : (wr_ctrl ? bus_wdata[CTRL_EN_BIT] : en);
   assign flush   = en & ~en_next;
   assign restart = en ^ en_next;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en     <= 1'b0;
         len    <= '0;
         order  <= '0;
         dma_en <= 1'b0;
         trig   <= '0;
         glb_ie <= 1'b0;
         req_ie <= 1'b0;
         fin_ie <= 1'b0;
      end else begin
         en <= en_next;
         if (wr_ctrl) begin
            len   <= wlen_clamped;
            order <= bus_wdata[CTRL_ORD_LSB +: ORD_W];
         end
         if (wr_dma) begin
            dma_en <= bus_wdata[DMA_EN_BIT];
            trig   <= bus_wdata[DMA_TRIG_LSB +: TRIG_W];
         end
         if (wr_ien) begin
            glb_ie <= bus_wdata[IEN_GLB_BIT];
            req_ie <= bus_wdata[IEN_REQ_BIT];
            fin_ie <= bus_wdata[IEN_FIN_BIT];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_flag <= 1'b0;
         fin_flag <= 1'b0;
      end else begin
         req_flag <= (req_flag & ~(wr_stat & bus_wdata[STAT_REQ_BIT])) | req_cond;
         fin_flag <= (fin_flag & ~(wr_stat & bus_wdata[STAT_FIN_BIT])) | fin_evt;
      end
   end

   assign irq = glb_ie & ((fin_flag & fin_ie) | (req_flag & req_ie));

   always_comb begin
      rdata = '0;
      case (bus_addr)
         A_CTRL: begin
            rdata[CTRL_EN_BIT]                 = en;
            rdata[CTRL_ORD_LSB +: ORD_W]       = order;
            rdata[CTRL_LEN_LSB +: LEN_W]       = len;
         end
         A_DMA: begin
            rdata[DMA_EN_BIT]                  = dma_en;
            rdata[DMA_TRIG_LSB +: TRIG_W]      = trig;
         end
         A_IEN: begin
            rdata[IEN_GLB_BIT]                 = glb_ie;
            rdata[IEN_REQ_BIT]                 = req_ie;
            rdata[IEN_FIN_BIT]                 = fin_ie;
         end
         A_STAT: begin
            rdata[STAT_FILL_LSB +: CNT_W]      = fill;
            rdata[STAT_REQ_BIT]                = req_flag;
            rdata[STAT_FIN_BIT]                = fin_flag;
         end
         default: rdata = '0;
      endcase
   end

   a_r8_done_disables: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done && en) |=> (!en && fin_flag));
   a_r11_req_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      req_cond |=> req_flag);
   a_r8_done_idle_noop: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done && !en && !wr_ctrl && !wr_stat) |=> $stable(fin_flag));
endmodule

// File: rtl/pixq_front.sv
module pixq_front
   import pixq_pkg::*;
#(
   parameter int unsigned DEPTH   = 32,
   parameter int unsigned LEN_W   = 13,
   parameter int unsigned MAX_PIX = 1024,
   parameter int unsigned TRIG_W  = 5,
   localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic [BUS_W-1:0]  px_data,
   output logic              px_valid,
   input  logic              px_ready,
   input  logic              frame_done,
   output logic              run_en,
   output logic [LEN_W-1:0]  frame_len,
   output logic [ORD_W-1:0]  color_order,
   output logic              dma_req,
   output logic              irq
);
   logic              flush, restart, data_wr, req_cond, dma_en;
   logic              f_full, f_empty;
   logic [CNT_W-1:0]  fill;
   logic [TRIG_W-1:0] trig;

   pixq_regs #(.LEN_W(LEN_W), .MAX_PIX(MAX_PIX), .TRIG_W(TRIG_W), .CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .frame_done(frame_done),
      .req_cond(req_cond), .fill(fill), .en(run_en), .len(frame_len),
      .order(color_order), .dma_en(dma_en), .trig(trig), .flush(flush),
      .restart(restart), .data_wr(data_wr), .rdata(bus_rdata), .irq(irq));

   pixq_fifo #(.WIDTH(BUS_W), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .flush(flush), .push(data_wr), .wdata(bus_wdata),
      .pop(px_ready), .rdata(px_data), .count(fill), .full(f_full), .empty(f_empty));

   pixq_reqgen #(.LEN_W(LEN_W), .TRIG_W(TRIG_W), .CNT_W(CNT_W)) u_req (
      .clk(clk), .rst_n(rst_n), .en(run_en), .restart(restart),
      .accepted(data_wr & ~f_full), .len(frame_len), .fill(fill), .trig(trig),
      .dma_en(dma_en), .req_cond(req_cond), .dma_req(dma_req));

   assign px_valid = ~f_empty;

   a_r5_valid_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      px_valid |-> run_en);
endmodule

// File: tb/sim_pixq_front.sv
module sim_pixq_front;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0, bus_write = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata, px_data;
   logic        px_valid, px_ready = 1'b0, frame_done = 1'b0;
   logic        run_en, dma_req, irq;
   logic [12:0] frame_len;
   logic [2:0]  color_order;

   always #2 clk = ~clk;

   pixq_front u0 (.*);

   int n_chk = 0, n_bad = 0, cycles = 0;
   bit finished = 0;

   // behavioural reference state
   bit          m_en, m_dma, m_glb, m_rie, m_fie, m_rflag, m_fflag;
   int          m_len, m_ord, m_trig, m_taken;
   logic [31:0] q[$];

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic bit m_req();
      return m_en && (q.size() < m_trig) && (m_taken < m_len);
   endfunction

   function automatic logic [31:0] m_read(logic [2:0] a);
      logic [31:0] r = '0;
      case (a)
         3'd0: begin r[0] = m_en; r[8:6] = 3'(m_ord); r[28:16] = 13'(m_len); end
         3'd1: begin r[5] = m_dma; r[4:0] = 5'(m_trig); end
         3'd2: begin r[5] = m_glb; r[1] = m_rie; r[0] = m_fie; end
         3'd3: begin r[15:10] = 6'(q.size()); r[1] = m_rflag; r[0] = m_fflag; end
         default: r = '0;
      endcase
      return r;
   endfunction

   task automatic m_step(bit v, bit w, logic [2:0] a, logic [31:0] d, bit rdy, bit fd);
      bit rc = m_req();
      int sz = q.size();
      bit wr = v && w;
      bit nen = m_en;
      if (wr && a == 3'd3) begin
         if (d[1]) m_rflag = 0;
         if (d[0]) m_fflag = 0;
      end
      if (rc) m_rflag = 1;
      if (fd && m_en) m_fflag = 1;
      if (rdy && sz > 0) void'(q.pop_front());
      if (wr && a == 3'd4 && m_en && sz < 32) begin q.push_back(d); m_taken++; end
      if (wr && a == 3'd0) begin
         nen = d[0];
         m_len = (d[28:16] > 1024) ? 1024 : int'(d[28:16]);
         m_ord = int'(d[8:6]);
      end
      if (fd && m_en) nen = 0;
      if (wr && a == 3'd1) begin m_dma = d[5]; m_trig = int'(d[4:0]); end
      if (wr && a == 3'd2) begin m_glb = d[5]; m_rie = d[1]; m_fie = d[0]; end
      if (!nen) q.delete();
      if (nen != m_en) m_taken = 0;
      m_en = nen;
   endtask

   task automatic compare_all();
      chk("R5 px_valid", px_valid, q.size() > 0);
      if (q.size() > 0) chk("R5 px_data", px_data, q[0]);
      chk("R6 dma_req", dma_req, m_dma && m_req());
      chk("R9 irq", irq, m_glb && ((m_fflag && m_fie) || (m_rflag && m_rie)));
      chk("R2 rdata", bus_rdata, m_read(bus_addr));
      chk("R2 run_en", run_en, m_en);
   endtask

   task automatic cyc(bit v, bit w, logic [2:0] a, logic [31:0] d, bit rdy, bit fd);
      bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = d;
      px_ready = rdy; frame_done = fd;
      #1;
      compare_all();
      @(posedge clk);
      m_step(v, w, a, d, rdy, fd);
      @(negedge clk);
   endtask

   task automatic wr(logic [2:0] a, logic [31:0] d); cyc(1, 1, a, d, 0, 0); endtask
   task automatic idle(bit rdy); cyc(0, 0, 3'd3, 0, rdy, 0); endtask

   task automatic expect_rd(logic [2:0] a, logic [31:0] exp, string tag);
      bus_valid = 0; bus_addr = a; px_ready = 0; frame_done = 0;
      #1;
      chk(tag, bus_rdata, exp);
      @(negedge clk);
   endtask

   initial begin
      while (!finished) begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d cycles", cycles, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 px_valid", px_valid, 0);
      chk("R1 dma_req", dma_req, 0);
      chk("R1 irq", irq, 0);
      chk("R1 run_en", run_en, 0);
      rst_n = 1'b1;
      for (int a = 0; a < 8; a++) expect_rd(3'(a), 32'h0, "R1 reg zero");

      // R2 / R3: field readback and clamp
      wr(3'd0, {3'b0, 13'd2000, 7'b0, 3'd5, 5'b0, 1'b0});
      expect_rd(3'd0, {3'b0, 13'd1024, 7'b0, 3'd5, 6'b0}, "R3 clamp 1024");
      chk("R3 frame_len port", frame_len, 13'd1024);
      chk("R2 color_order", color_order, 3'd5);
      wr(3'd0, {3'b0, 13'd1024, 16'b0});
      expect_rd(3'd0, {3'b0, 13'd1024, 16'b0}, "R3 1024 kept");
      wr(3'd1, 32'h0000_0030);
      expect_rd(3'd1, 32'h0000_0030, "R2 dma field");
      wr(3'd2, 32'h0000_0023);
      expect_rd(3'd2, 32'h0000_0023, "R2 ien field");
      wr(3'd4, 32'hDEAD_0001);
      expect_rd(3'd4, 32'h0, "R2 data reads zero");
      // R4: the push above happened while disabled
      expect_rd(3'd3, 32'h0, "R4 push dropped when disabled");

      // frame of 40, trigger 16, DMA on
      wr(3'd0, {3'b0, 13'd40, 16'h0001});
      chk("R6 request on empty", dma_req, 1);
      for (int i = 0; i < 33; i++) wr(3'd4, 32'hA000_0000 + i);
      expect_rd(3'd3, {16'b0, 6'd32, 10'b0} | 32'h2, "R4 full at 32, R11 flag");
      chk("R6 no request when full", dma_req, 0);
      chk("R9 irq from request", irq, 1);
      wr(3'd3, 32'h2);
      chk("R10 w1c request flag", bus_rdata[1:0], 2'b00);
      chk("R5 head word", px_data, 32'hA000_0000);
      for (int i = 0; i < 20; i++) idle(1);
      chk("R5 order after drain", px_data, 32'hA000_0014);
      chk("R6 request resumes", dma_req, 1);
      for (int i = 0; i < 8; i++) wr(3'd4, 32'hB000_0000 + i);
      chk("R6 request stops at frame length", dma_req, 0);
      for (int i = 0; i < 25; i++) idle(1);
      chk("R5 drained", px_valid, 0);
      chk("R6 no request when frame exhausted", dma_req, 0);
      cyc(0, 0, 3'd3, 0, 0, 1);
      chk("R8 enable cleared", run_en, 0);
      chk("R8 finish flag", bus_rdata[0], 1);
      wr(3'd3, 32'h3);
      cyc(0, 0, 3'd3, 0, 0, 1);
      chk("R8 done ignored when idle", bus_rdata[1:0], 2'b00);

      // R7: disable flushes
      wr(3'd0, {3'b0, 13'd10, 16'h0001});
      for (int i = 0; i < 4; i++) wr(3'd4, 32'hC000_0000 + i);
      wr(3'd0, 32'h0);
      expect_rd(3'd3, 32'h0000_0002, "R7 flush empties FIFO");
      chk("R7 no valid after flush", px_valid, 0);

      // R10: set beats clear in the same cycle
      wr(3'd0, {3'b0, 13'd10, 16'h0001});
      wr(3'd3, 32'h2);
      chk("R10 set wins over clear", bus_rdata[1], 1);

      // random phase against the model
      for (int i = 0; i < 20000; i++) begin
         int r = $urandom_range(0, 99);
         logic [2:0]  a = 3'($urandom_range(0, 7));
         logic [31:0] d = $urandom;
         if (r < 40) a = 3'd4;
         if (a == 3'd0) begin
            d[0] = ($urandom_range(0, 9) != 0);
            d[28:16] = ($urandom_range(0, 9) == 0) ? 13'($urandom) : 13'($urandom_range(0, 60));
         end
         if (a == 3'd3 && $urandom_range(0, 3) != 0) d[1:0] = 2'b00;
         cyc($urandom_range(0, 1) == 1, $urandom_range(0, 4) != 0, a, d,
             $urandom_range(0, 2) == 0, $urandom_range(0, 49) == 0);
      end

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule